// File: doc/BRIEF.md
# Nonvolatile Data Memory Controller

This block sits beside a CPU and gives firmware byte access to a small nonvolatile data store through three registers on a simple synchronous register bus: a control register, an address register and a data register. A read or write cycle is requested in two steps. Firmware first sets the enable bit for that direction in one bus write, then sets the trigger bit in a later bus write. The trigger bit stays at 1 while the cycle runs and is cleared by hardware when the cycle ends, so firmware polls it as a busy flag.

The storage is an internal register array of 2^ADDR_W bytes. A write cycle lasts WRITE_CYCLES clocks, which stands in for the long programming time of a real cell, and then stores the data register into the addressed byte. A read cycle lasts READ_CYCLES clocks and then loads the addressed byte into the data register. While a cycle runs, every register write on the bus is dropped.

The sequencer has three states. ST_IDLE accepts register writes. It takes the transition idle-to-write when a control write asks for a write cycle and is allowed to start one, and idle-to-read in the same way for a read cycle. ST_WRITE counts down and takes write-done back to ST_IDLE, storing the byte on that edge. ST_READ counts down and takes read-done back to ST_IDLE, loading the data register on that edge.

Top module: `nvm_data_ctrl`

## Requirements
- R1: Register select 0 is the control register, 1 the address register, 2 the data register, and 3 reads as zero. In the control register, bit 0 is the read trigger, bit 1 the read enable, bit 2 the write trigger and bit 3 the write enable. Control bits 7 to 4 always read as 0.
- R2: After reset, the four control bits read 0 and no cycle is running. The address and data registers are undefined after reset.
- R3: A control write with bit 2 set starts a write cycle only if the write enable was already 1 before that bus write. A single write that sets bits 3 and 2 together starts nothing.
- R4: A control write with bit 0 set starts a read cycle only if the read enable was already 1 before that bus write. A single write that sets bits 1 and 0 together starts nothing.
- R5: The write trigger reads 1 for exactly WRITE_CYCLES clocks after the accepting edge. Hardware then clears it, and the data register is stored at the addressed location.
- R6: The read trigger reads 1 for exactly READ_CYCLES clocks. Hardware then clears it, and the data register holds the byte stored at the addressed location.
- R7: A control write with bits 2 and 0 both set starts no cycle and leaves both triggers at 0. Its enable bits are still written.
- R8: While either trigger is 1, bus writes to the control, address and data registers are ignored.
- R9: Clearing an enable bit prevents any later trigger in that direction from starting a cycle.
- R10: The read and write triggers are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 2 | Register select (0 control, 1 address, 2 data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |

## Verification
The reference model is stepped on every clock and its state is compared against whichever register the bench is selecting. Control writes are tried in four forms: enable first and trigger later, enable and trigger in one write, both triggers in one write, and trigger after the enable was cleared. Together these separate a correct enable-before-trigger rule from one that reads the incoming enable bit or ignores enables altogether. Writes and reads to two addresses with different data show that the address register steers both the store and the fetch. Bus writes issued in the middle of both kinds of cycle show whether the busy lock covers all three registers.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } nvm_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int BIT_RD_GO = 0;
    localparam int BIT_RD_EN = 1;
    localparam int BIT_WR_GO = 2;
    localparam int BIT_WR_EN = 3;

endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int WRITE_CYCLES = 16,
    parameter int READ_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_acc,
    input  logic req_wr,
    input  logic req_rd,
    input  logic wren_q,
    input  logic rden_q,
    output logic idle,
    output logic wr_busy,
    output logic rd_busy,
    output logic commit,
    output logic load
);
    localparam int MAX_CYC = (WRITE_CYCLES > READ_CYCLES) ? WRITE_CYCLES : READ_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    nvm_state_e state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic start_wr, start_rd, cnt_zero;

    assign start_wr = ctrl_acc && req_wr && !req_rd && wren_q;
    assign start_rd = ctrl_acc && req_rd && !req_wr && rden_q;
    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_IDLE) begin
            if (start_wr) begin
                cnt <= CNT_W'(WRITE_CYCLES - 1);
            end else if (start_rd) begin
                cnt <= CNT_W'(READ_CYCLES - 1);
            end
        end else if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_wr) begin
                    state_nxt = ST_WRITE;
                end else if (start_rd) begin
                    state_nxt = ST_READ;
                end
            end
            ST_WRITE: if (cnt_zero) state_nxt = ST_IDLE;
            ST_READ:  if (cnt_zero) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        idle    = 1'b0;
        wr_busy = 1'b0;
        rd_busy = 1'b0;
        commit  = 1'b0;
        load    = 1'b0;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_WRITE: begin
                wr_busy = 1'b1;
                commit  = cnt_zero;
            end
            ST_READ: begin
                rd_busy = 1'b1;
                load    = cnt_zero;
            end
            default: idle = 1'b1;
        endcase
    end
endmodule

// File: rtl/nvm_data_ctrl.sv
module nvm_data_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 16,
    parameter int READ_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    logic              wren_q, rden_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [7:0]        rd_byte;
    logic [7:0]        addr_view;
    logic              idle, wr_busy, rd_busy, commit, load;
    logic              bus_wr, ctrl_acc, addr_acc, data_acc;

    assign bus_wr   = bus_sel && bus_we && idle;
    assign ctrl_acc = bus_wr && (bus_addr == SEL_CTRL);
    assign addr_acc = bus_wr && (bus_addr == SEL_ADDR);
    assign data_acc = bus_wr && (bus_addr == SEL_DATA);

    nvm_seq #(
        .WRITE_CYCLES (WRITE_CYCLES),
        .READ_CYCLES  (READ_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_acc (ctrl_acc),
        .req_wr   (bus_wdata[BIT_WR_GO]),
        .req_rd   (bus_wdata[BIT_RD_GO]),
        .wren_q   (wren_q),
        .rden_q   (rden_q),
        .idle     (idle),
        .wr_busy  (wr_busy),
        .rd_busy  (rd_busy),
        .commit   (commit),
        .load     (load)
    );

    nvm_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_array (
        .clk   (clk),
        .we    (commit),
        .addr  (addr_q),
        .wdata (data_q),
        .rdata (rd_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wren_q <= 1'b0;
            rden_q <= 1'b0;
        end else if (ctrl_acc) begin
            wren_q <= bus_wdata[BIT_WR_EN];
            rden_q <= bus_wdata[BIT_RD_EN];
        end
    end

    always_ff @(posedge clk) begin
        if (addr_acc) begin
            addr_q <= bus_wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            data_q <= rd_byte;
        end else if (data_acc) begin
            data_q <= bus_wdata;
        end
    end

    always_comb begin
        addr_view = '0;
        addr_view[ADDR_W-1:0] = addr_q;
    end

    always_comb begin
        unique case (bus_addr)
            SEL_CTRL: bus_rdata = {4'b0000, wren_q, wr_busy, rden_q, rd_busy};
            SEL_ADDR: bus_rdata = addr_view;
            SEL_DATA: bus_rdata = data_q;
            default:  bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/nvm_data_ctrl_chk.sv
module nvm_data_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              wr_busy,
    input logic              rd_busy,
    input logic              wren_q,
    input logic              rden_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [7:0]        data_q,
    input logic [7:0]        rd_byte,
    input logic              commit,
    input logic              load
);
    logic busy, ctrl_req;
    assign busy     = wr_busy || rd_busy;
    assign ctrl_req = bus_sel && bus_we && (bus_addr == 2'd0) && !busy;

    // R10
    trig_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_busy, rd_busy}));

    // R1
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[7:4] == 4'h0));

    // R3
    wr_needs_prior_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_req && bus_wdata[2] && !wren_q) |=> !wr_busy);

    // R4
    rd_needs_prior_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_req && bus_wdata[0] && !rden_q) |=> !rd_busy);

    // R7
    dual_trigger_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_req && bus_wdata[2] && bus_wdata[0]) |=> !busy);

    // R8
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (addr_q == $past(addr_q)));

    // R8
    busy_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wren_q) && $stable(rden_q)));

    // R8
    write_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |=> (data_q == $past(data_q)));

    // R5
    commit_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wr_busy);

    // R5
    write_end_has_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |-> $past(commit));

    // R6
    read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!rd_busy && (data_q == $past(rd_byte))));
endmodule

bind nvm_data_ctrl nvm_data_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wr_busy   (wr_busy),
    .rd_busy   (rd_busy),
    .wren_q    (wren_q),
    .rden_q    (rden_q),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .rd_byte   (rd_byte),
    .commit    (commit),
    .load      (load)
);

// File: tb/sim_nvm_data_ctrl.sv
module sim_nvm_data_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WR_CYC     = 16;
    localparam int RD_CYC     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_data_ctrl #(
        .ADDR_W       (8),
        .WRITE_CYCLES (WR_CYC),
        .READ_CYCLES  (RD_CYC)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R2";
    bit    done = 1'b0;

    // behavioural reference model
    bit         m_wren = 0, m_rden = 0, m_wgo = 0, m_rgo = 0;
    int         m_rem = 0;
    logic [7:0] m_addr, m_data;
    bit         m_av = 0, m_dv = 0;
    logic [7:0] m_mem [256];
    bit         m_mv  [256];
    bit         conf, ws, rs;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wren = 0; m_rden = 0; m_wgo = 0; m_rgo = 0; m_rem = 0;
        end else if (m_wgo || m_rgo) begin
            m_rem = m_rem - 1;
            if (m_rem == 0) begin
                if (m_wgo) begin
                    m_mem[m_addr] = m_data;
                    m_mv[m_addr]  = 1;
                    m_wgo = 0;
                end else begin
                    m_data = m_mem[m_addr];
                    m_dv   = m_mv[m_addr];
                    m_rgo  = 0;
                end
            end
        end else if (bus_sel && bus_we) begin
            case (bus_addr)
                2'd0: begin
                    conf = bus_wdata[2] && bus_wdata[0];
                    ws = bus_wdata[2] && m_wren && !conf;
                    rs = bus_wdata[0] && m_rden && !conf;
                    m_wren = bus_wdata[3];
                    m_rden = bus_wdata[1];
                    if (ws) begin m_wgo = 1; m_rem = WR_CYC; end
                    if (rs) begin m_rgo = 1; m_rem = RD_CYC; end
                end
                2'd1: begin m_addr = bus_wdata; m_av = 1; end
                2'd2: begin m_data = bus_wdata; m_dv = 1; end
                default: ;
            endcase
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            case (bus_addr)
                2'd0: check(bus_rdata, {4'b0000, m_wren, m_wgo, m_rden, m_rgo}, "control");
                2'd1: if (m_av) check(bus_rdata, m_addr, "address");
                2'd2: if (m_dv) check(bus_rdata, m_data, "data");
                default: check(bus_rdata, 8'h00, "unused select");
            endcase
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(posedge clk); #2;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #2;
        bus_sel = 0; bus_we = 0; bus_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(posedge clk); #2;
        bus_addr = a;
        @(posedge clk); #2;
        bus_addr = 2'd0;
    endtask

    task automatic wait_done();
        while (m_wgo || m_rgo) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog %s: actual hung expected finished", cur_req);
            finish_run();
        end
    end

    initial begin
        // R2: reset state
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1: layout, upper bits, unused select
        cur_req = "R1";
        wr(2'd0, 8'hF0);
        wr(2'd0, 8'hFA);
        rd(2'd3);

        // R3: enable and trigger together start nothing
        cur_req = "R3";
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h0C);
        repeat (3) @(posedge clk);

        // R5: write cycle length and commit
        cur_req = "R5";
        wr(2'd1, 8'h12);
        wr(2'd2, 8'hA5);
        wr(2'd0, 8'h0C);
        // R8: writes during a write cycle are dropped
        cur_req = "R8";
        wr(2'd1, 8'h55);
        wr(2'd2, 8'h66);
        wr(2'd0, 8'h03);
        wait_done();
        rd(2'd1);
        rd(2'd2);
        cur_req = "R5";
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h3C);
        wr(2'd0, 8'h0C);
        wait_done();

        // R4: read enable and trigger together start nothing
        cur_req = "R4";
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h03);
        repeat (3) @(posedge clk);

        // R6: read cycles from two locations
        cur_req = "R6";
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h12);
        wr(2'd0, 8'h03);
        wait_done();
        rd(2'd2);
        wr(2'd1, 8'h34);
        wr(2'd0, 8'h03);
        wait_done();
        rd(2'd2);

        // R8: data write during a read cycle is dropped
        cur_req = "R8";
        wr(2'd1, 8'h12);
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h77);
        wait_done();
        rd(2'd2);
        rd(2'd1);

        // R7 R10: both triggers in one write
        cur_req = "R7 R10";
        wr(2'd0, 8'h0A);
        wr(2'd0, 8'h0F);
        repeat (2) @(posedge clk);
        wr(2'd0, 8'h05);
        repeat (2) @(posedge clk);

        // R9: cleared enable blocks later triggers
        cur_req = "R9";
        wr(2'd0, 8'h0A);
        wr(2'd0, 8'h02);
        wr(2'd0, 8'h06);
        repeat (2) @(posedge clk);
        wr(2'd0, 8'h08);
        wr(2'd0, 8'h09);
        repeat (3) @(posedge clk);

        finish_run();
    end
endmodule